// File: doc/BRIEF.md
# Sector Erase Collection Window

This block gathers a burst of sector-erase requests into one erase run. The first valid sector-erase strobe opens an acceptance window and marks that sector in a bitmap. Each further valid sector-erase strobe that arrives while the window is open marks its sector and restarts the window. Sectors may arrive in any order, and the count may be anywhere from one sector to every sector. When the window runs out, the block pulses an erase-start strobe for the erase engine. It then holds the bitmap until the engine acknowledges, and clears it on that acknowledge.

The inputs are strobes from an upstream command decoder: sector erase (with a sector index), erase suspend, and a strobe for any other command. A foreign command that arrives inside the window cancels the collection and returns the block to idle. A suspend strobe does not cancel it. The window length in clock cycles is the clock frequency in MHz times the window length in microseconds, so the default is a 50 µs window at 250 MHz.

The states are IDLE, COLLECT, LAUNCH and WAIT_ACK. The transitions are:
- IDLE→COLLECT on a valid sector erase.
- COLLECT→COLLECT on a valid sector erase, which restarts the window.
- COLLECT→IDLE on a foreign command (abort).
- COLLECT→LAUNCH when the window expires.
- LAUNCH→WAIT_ACK when there is no acknowledge.
- LAUNCH→IDLE or WAIT_ACK→IDLE on an acknowledge.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `sector_map` is all zero and `erase_start` and `erase_busy` are low.
- R2: In idle, a sector-erase strobe with a valid index sets bit `sect_idx` of `sector_map` (bit i stands for sector i) from the next cycle. It opens the window, and `erase_busy` stays low.
- R3: While the window is open, each valid sector-erase strobe sets its bit, in any order and with repeats allowed, and restarts the window. A strobe sampled up to and including WIN clock edges after the previous accepted one is taken. A strobe sampled later than that is not taken.
- R4: `erase_start` is high for exactly one cycle. It rises on the WIN-th clock edge after the edge that sampled the last accepted strobe, and at that moment `sector_map` holds every collected sector.
- R5: A foreign-command strobe (`cmd_other` high, with `cmd_suspend` and `cmd_sect_erase` low) during the window clears `sector_map` and returns to idle, and no `erase_start` follows.
- R6: A `cmd_suspend` strobe during the window neither cancels the window nor restarts it.
- R7: `erase_busy` (the window-expired status) is low in idle and during the window. It is high from the `erase_start` cycle until the acknowledge is taken.
- R8: While `erase_busy` is high, `sector_map` holds its value and every command strobe is ignored. An `erase_ack` sampled while busy clears `sector_map` and drops `erase_busy` on the next edge.
- R9: A sector-erase strobe whose index is NSECT or more is ignored. It sets no bit, opens no window and does not restart a window.
- R10: All NSECT sectors can be collected into one erase run.
- R11: After an acknowledge, a new valid sector-erase strobe opens a fresh window with only its own bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_sect_erase | input | 1 | Decoded sector-erase command strobe |
| cmd_suspend | input | 1 | Decoded erase-suspend command strobe |
| cmd_other | input | 1 | Strobe for any other decoded command |
| sect_idx | input | IW | Sector index that goes with `cmd_sect_erase` |
| erase_ack | input | 1 | Erase engine has taken the bitmap |
| sector_map | output | NSECT | Collected sector bitmap |
| erase_start | output | 1 | One-cycle strobe that starts the erase engine |
| erase_busy | output | 1 | Window expired and erase handed off |

## Verification
A single strobe tells whether the window length is right, measured from the command edge. Strobes spaced below the window, in scrambled order and with a repeat, tell a restarting window apart from one that runs from the first command. A strobe placed exactly on the last accepted edge and another one edge later check the boundary of the window in both directions. Suspend and out-of-range strobes inside the window would shift the start cycle if they restarted the timer, and a foreign strobe or a late sector strobe would show up as an unexpected or altered erase start.

// File: rtl/secwin_pkg.sv
package secwin_pkg;
    typedef enum logic [1:0] {
        SW_IDLE,
        SW_COLLECT,
        SW_LAUNCH,
        SW_WAIT_ACK
    } secwin_state_e;
endpackage

// File: rtl/secwin_timer.sv
// Down-counter for the acceptance window; reloads on every accepted command.
module secwin_timer #(
    parameter int unsigned TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(TICKS - 1);
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/secwin_map.sv
// Sector bitmap: one flop per sector, set by index, cleared as a whole.
module secwin_map #(
    parameter int unsigned NSECT = 19,
    parameter int unsigned IW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IW-1:0]    set_idx,
    input  logic             clr,
    output logic [NSECT-1:0] map
);
    for (genvar g = 0; g < NSECT; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map[g] <= 1'b0;
            end else if (clr) begin
                map[g] <= 1'b0;
            end else if (set_en && (set_idx == IW'(g))) begin
                map[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
    import secwin_pkg::*;
#(
    parameter  int unsigned CLK_MHZ   = 250,
    parameter  int unsigned WINDOW_US = 50,
    parameter  int unsigned NSECT     = 19,
    localparam int unsigned IW        = (NSECT > 1) ? $clog2(NSECT) : 1,
    localparam int unsigned WIN       = CLK_MHZ * WINDOW_US
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_sect_erase,
    input  logic             cmd_suspend,
    input  logic             cmd_other,
    input  logic [IW-1:0]    sect_idx,
    input  logic             erase_ack,
    output logic [NSECT-1:0] sector_map,
    output logic             erase_start,
    output logic             erase_busy
);
    secwin_state_e state, state_nx;

    logic idx_ok, accept, abort;
    logic tmr_load, tmr_run, tmr_expired;
    logic map_set, map_clr;

    assign idx_ok = ({1'b0, sect_idx} < (IW + 1)'(NSECT));
    assign accept = cmd_sect_erase && idx_ok;
    // A suspend strobe masks a foreign strobe in the same cycle.
    assign abort  = cmd_other && !cmd_suspend && !cmd_sect_erase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SW_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SW_IDLE:     if (accept) state_nx = SW_COLLECT;
            SW_COLLECT: begin
                if (accept)           state_nx = SW_COLLECT;
                else if (abort)       state_nx = SW_IDLE;
                else if (tmr_expired) state_nx = SW_LAUNCH;
            end
            SW_LAUNCH:   state_nx = erase_ack ? SW_IDLE : SW_WAIT_ACK;
            SW_WAIT_ACK: if (erase_ack) state_nx = SW_IDLE;
            default:     state_nx = SW_IDLE;
        endcase
    end

    always_comb begin
        tmr_load    = 1'b0;
        tmr_run     = 1'b0;
        map_set     = 1'b0;
        map_clr     = 1'b0;
        erase_start = 1'b0;
        erase_busy  = 1'b0;
        unique case (state)
            SW_IDLE: begin
                map_set  = accept;
                tmr_load = accept;
            end
            SW_COLLECT: begin
                map_set  = accept;
                tmr_load = accept;
                tmr_run  = 1'b1;
                map_clr  = !accept && abort;
            end
            SW_LAUNCH: begin
                erase_start = 1'b1;
                erase_busy  = 1'b1;
                map_clr     = erase_ack;
            end
            SW_WAIT_ACK: begin
                erase_busy = 1'b1;
                map_clr    = erase_ack;
            end
            default: ;
        endcase
    end

    secwin_timer #(.TICKS(WIN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    secwin_map #(.NSECT(NSECT), .IW(IW)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (map_set),
        .set_idx (sect_idx),
        .clr     (map_clr),
        .map     (sector_map)
    );
endmodule

// File: rtl/secwin_checker.sv
module secwin_checker #(
    parameter int unsigned NSECT = 19,
    parameter int unsigned IW    = 5,
    parameter int unsigned WIN   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_sect_erase,
    input logic             cmd_suspend,
    input logic             cmd_other,
    input logic [IW-1:0]    sect_idx,
    input logic             erase_ack,
    input logic [NSECT-1:0] sector_map,
    input logic             erase_start,
    input logic             erase_busy
);
    logic        good_idx;
    int unsigned gap;

    assign good_idx = ({1'b0, sect_idx} < (IW + 1)'(NSECT));

    // Cycles since the last accepted sector-erase strobe, saturating past WIN.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= 0;
        end else if (cmd_sect_erase && good_idx && !erase_busy) begin
            gap <= 0;
        end else if ((sector_map != '0) && !erase_busy && (gap <= WIN)) begin
            gap <= gap + 1;
        end
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    a_r4_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (gap == WIN));

    a_r4_map_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (sector_map != '0));

    a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> erase_busy);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && !erase_ack) |=> ($stable(sector_map) && erase_busy));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && erase_ack) |=> ((sector_map == '0) && !erase_busy));

    a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase_busy && (sector_map != '0) && cmd_other && !cmd_suspend && !cmd_sect_erase)
        |=> ((sector_map == '0) && !erase_busy));

    a_r9_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase_busy && cmd_sect_erase && !good_idx && !cmd_other) |=> $stable(sector_map));
endmodule

bind sector_erase_window secwin_checker #(.NSECT(NSECT), .IW(IW), .WIN(WIN)) u_secwin_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_sect_erase (cmd_sect_erase),
    .cmd_suspend    (cmd_suspend),
    .cmd_other      (cmd_other),
    .sect_idx       (sect_idx),
    .erase_ack      (erase_ack),
    .sector_map     (sector_map),
    .erase_start    (erase_start),
    .erase_busy     (erase_busy)
);

// File: tb/sector_erase_window_bench.sv
`timescale 1ns/1ps
module sector_erase_window_bench;
    localparam int NS = 19;
    localparam int IW = 5;
    localparam int W  = 8;  // 2 MHz x 4 us

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_sect_erase = 1'b0;
    logic          cmd_suspend = 1'b0;
    logic          cmd_other = 1'b0;
    logic [IW-1:0] sect_idx = '0;
    logic          erase_ack = 1'b0;
    logic [NS-1:0] sector_map;
    logic          erase_start;
    logic          erase_busy;

    always #2 clk = ~clk;

    sector_erase_window #(.CLK_MHZ(2), .WINDOW_US(4), .NSECT(NS)) u_sector_erase_window (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_sect_erase (cmd_sect_erase),
        .cmd_suspend    (cmd_suspend),
        .cmd_other      (cmd_other),
        .sect_idx       (sect_idx),
        .erase_ack      (erase_ack),
        .sector_map     (sector_map),
        .erase_start    (erase_start),
        .erase_busy     (erase_busy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    int last_cmd = 0;

    typedef struct {
        logic [NS-1:0] map;
        int            at;
    } exp_t;
    exp_t expq[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_se(int idx);
        cmd_sect_erase = 1'b1;
        sect_idx = IW'(idx);
        @(negedge clk);
        cmd_sect_erase = 1'b0;
        if (idx < NS) last_cmd = cyc;
    endtask

    task automatic send_other();
        cmd_other = 1'b1;
        @(negedge clk);
        cmd_other = 1'b0;
    endtask

    task automatic send_suspend();
        cmd_suspend = 1'b1;
        @(negedge clk);
        cmd_suspend = 1'b0;
    endtask

    // Driver side of the scoreboard: expected bitmap and start cycle.
    task automatic expect_start(logic [NS-1:0] m);
        exp_t e;
        e.map = m;
        e.at  = last_cmd + W;
        expq.push_back(e);
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 3 * W && !erase_busy; i++) @(negedge clk);
        chk("R7 busy after expiry", 32'(erase_busy), 32'd1);
    endtask

    task automatic ack();
        erase_ack = 1'b1;
        @(negedge clk);
        erase_ack = 1'b0;
    endtask

    // Monitor side of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && erase_start) begin
            if (expq.size() == 0) begin
                chk("R5 unexpected erase_start", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk("R4 bitmap at start", 32'(sector_map), 32'(e.map));
                chk("R4 start cycle", 32'(cyc), 32'(e.at));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 map reset", 32'(sector_map), 32'd0);
        chk("R1 start reset", 32'(erase_start), 32'd0);
        chk("R1 busy reset", 32'(erase_busy), 32'd0);
        rst_n = 1'b1;
        idle(1);

        // Single sector, then commands while busy
        send_se(3);
        chk("R2 bit set", 32'(sector_map), 32'h8);
        chk("R2 busy low in window", 32'(erase_busy), 32'd0);
        expect_start(NS'(32'h8));
        wait_busy();
        send_other();
        send_se(5);
        chk("R8 map held while busy", 32'(sector_map), 32'h8);
        ack();
        chk("R8 map cleared on ack", 32'(sector_map), 32'd0);
        chk("R8 busy dropped on ack", 32'(erase_busy), 32'd0);

        // Any order with a repeat, window restarts
        send_se(10);
        chk("R11 fresh window", 32'(sector_map), 32'h400);
        idle(5);
        send_se(2);
        idle(6);
        send_se(10);
        idle(2);
        send_se(0);
        chk("R3 collected", 32'(sector_map), 32'h405);
        chk("R3 still open", 32'(erase_busy), 32'd0);
        expect_start(NS'(32'h405));
        wait_busy();
        ack();

        // Suspend does not restart or cancel
        send_se(7);
        idle(2);
        send_suspend();
        chk("R6 map kept", 32'(sector_map), 32'h80);
        chk("R6 window open", 32'(erase_busy), 32'd0);
        expect_start(NS'(32'h80));
        wait_busy();
        ack();

        // Boundary: last accepted edge
        send_se(1);
        idle(W - 1);
        send_se(4);
        chk("R3 boundary accepted", 32'(sector_map), 32'h12);
        expect_start(NS'(32'h12));
        wait_busy();
        ack();

        // Boundary: one edge too late
        send_se(6);
        expect_start(NS'(32'h40));
        idle(W);
        send_se(9);
        chk("R3 late not taken", 32'(sector_map), 32'h40);
        wait_busy();
        ack();

        // Abort by foreign command
        send_se(4);
        idle(3);
        send_other();
        chk("R5 map cleared", 32'(sector_map), 32'd0);
        chk("R5 back to idle", 32'(erase_busy), 32'd0);
        idle(2 * W);
        chk("R5 no start", 32'(erase_busy), 32'd0);

        // Out-of-range index
        send_se(25);
        chk("R9 idle bad index", 32'(sector_map), 32'd0);
        idle(2 * W);
        chk("R9 no window", 32'(erase_busy), 32'd0);
        send_se(11);
        expect_start(NS'(32'h800));
        idle(3);
        send_se(30);
        wait_busy();
        chk("R9 bad index in window", 32'(sector_map), 32'h800);
        ack();

        // Every sector
        for (int i = NS - 1; i >= 0; i--) send_se(i);
        chk("R10 all sectors", 32'(sector_map), 32'h7FFFF);
        expect_start(NS'(32'h7FFFF));
        wait_busy();
        ack();
        chk("R10 cleared", 32'(sector_map), 32'd0);

        idle(2);
        chk("R4 scoreboard drained", 32'(expq.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule